// File: doc/BRIEF.md
# Clock-Slave Serial Frame Receiver

This block takes a serial backplane stream in which the system side supplies both the bit clock and the framing pulse. The receiver runs on a faster local clock and oversamples the external bit clock to find its rising and falling edges. It samples the frame pulse on one chosen edge type and samples data and signaling on another. It then tracks the bit position inside each frame and turns the stream into channel bytes. Each channel byte comes out together with its channel index and the signaling byte received alongside it.

Configuration inputs set the following:
- which edge samples the frame pulse;
- which edge samples data and signaling;
- whether the bit clock runs at the bit rate or at twice the bit rate (and, at twice the rate, which of the two edges of a bit is used);
- the pulse polarity;
- whether the pulse marks every frame or only multiframe starts;
- a 193-bit or a 256-bit frame.

A period checker compares the bit count between successive pulses with the frame length. A count that is not a whole number of frames sets a sticky error flag. The error flag drives a maskable interrupt.

Top module: `slave_frame_rx`

## Requirements
- R1: While rst_n is low, byte_valid, byte_data, sig_byte, byte_chan, frame_start, mf_start, err_sticky and irq are all 0.
- R2: The frame pulse is sampled only on bit-clock rising edges when cfg_fp_edge=0 and only on falling edges when it is 1. Data and signaling are sampled on rising edges when cfg_data_edge=0 and on falling edges when it is 1.
- R3: When both edge selects are equal, the data sampled on the same edge as an active pulse is bit 0 of the frame. When they differ, bit 0 is the data sampled on the next data edge after the pulse.
- R4: With cfg_dbl=1, every bit spans two data-type edges, counted from the edge that holds bit 0's first half. cfg_dbl_pick=0 takes the first of the two edges and 1 takes the second. The pulse is expected on the first edge.
- R5: The pulse is active high when cfg_fp_low=0 and active low when cfg_fp_low=1.
- R6: With cfg_t1=1 a frame has 193 bits: bit 0 is a framing bit that produces no byte, and channels 0..23 follow. With cfg_t1=0 a frame has 256 bits forming channels 0..31. The first bit received is byte bit 7. After a channel's eighth bit, byte_valid pulses for one cycle with byte_chan, byte_data and sig_byte.
- R7: frame_start pulses for one cycle each time bit 0 of a frame is sampled. This includes frames that begin by counter wrap with no pulse.
- R8: mf_start pulses together with frame_start only when cfg_fp_multi=1 and that frame was started by an active pulse. Otherwise mf_start stays 0.
- R9: Before the first active pulse after reset, no byte_valid and no frame_start appear.
- R10: A pulse that arrives after a bit count that is not a whole number of frame lengths since the previous pulse sets err_sticky. The first pulse after reset never sets it.
- R11: err_sticky holds until err_clr is high at a clock edge. A new error in the same cycle wins over the clear.
- R12: irq is 1 exactly when err_sticky is 1 and cfg_err_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External bit clock from the system side |
| fp_in | input | 1 | External frame pulse |
| sd_in | input | 1 | Serial data |
| sig_in | input | 1 | Serial signaling, channel-aligned with data |
| cfg_fp_edge | input | 1 | Pulse sampling edge: 0 rising, 1 falling |
| cfg_data_edge | input | 1 | Data/signaling sampling edge: 0 rising, 1 falling |
| cfg_dbl | input | 1 | Bit clock at twice the bit rate |
| cfg_dbl_pick | input | 1 | In double mode: 0 first edge, 1 second edge |
| cfg_fp_multi | input | 1 | Pulse marks multiframe starts |
| cfg_fp_low | input | 1 | Pulse active low |
| cfg_t1 | input | 1 | 1: 193-bit frame, 0: 256-bit frame |
| cfg_err_en | input | 1 | Interrupt enable for the period error |
| err_clr | input | 1 | Clear strobe for err_sticky |
| byte_valid | output | 1 | Channel byte complete |
| byte_data | output | 8 | Channel data byte |
| sig_byte | output | 8 | Channel signaling byte |
| byte_chan | output | 5 | Channel index of the byte |
| frame_start | output | 1 | Bit 0 of a frame sampled |
| mf_start | output | 1 | Frame started by a multiframe pulse |
| err_sticky | output | 1 | Pulse period error, sticky |
| irq | output | 1 | Masked interrupt |

## Verification
Two situations are hard to reach from the ports. The first is double-rate mode with the second edge picked, because a design that samples the wrong half of each bit can still produce plausible bytes. The bench therefore drives the edge that is not picked with the inverted bit value, so any wrong choice corrupts every byte. The second is the period error: it needs a pulse that lands one bit late. The bench reaches it by inserting a single filler bit before a frame. The free-running wrap and the multiframe flag are exercised by leaving out the pulse on one frame in the middle of a run.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   typedef struct packed {
      logic fp_edge;
      logic data_edge;
      logic dbl;
      logic dbl_pick;
      logic fp_multi;
      logic fp_low;
      logic t1;
   } rx_cfg_t;
endpackage

// File: rtl/sfr_sync_edge.sv
module sfr_sync_edge #(
   parameter int STAGES = 2,
   parameter int DW     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bclk_in,
   input  logic [DW-1:0] din,
   output logic          rise,
   output logic          fall,
   output logic [DW-1:0] dout
);
   timeunit 1ns; timeprecision 1ps;

   if (STAGES < 2) begin : g_bad_stages
      $error("sfr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0][DW:0] stg;
   logic                    bclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg       <= '0;
         bclk_prev <= 1'b0;
      end else begin
         stg       <= {stg[STAGES-2:0], {bclk_in, din}};
         bclk_prev <= stg[STAGES-1][DW];
      end
   end

   assign rise = stg[STAGES-1][DW] & ~bclk_prev;
   assign fall = ~stg[STAGES-1][DW] & bclk_prev;
   assign dout = stg[STAGES-1][DW-1:0];
endmodule

// File: rtl/sfr_bit_timer.sv
module sfr_bit_timer import sfr_pkg::*; #(
   parameter int IDX_W   = 8,
   parameter int T1_BITS = 193,
   parameter int E1_BITS = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             fall,
   input  logic             fp_raw,
   input  rx_cfg_t          cfg,
   output logic             smp,
   output logic [IDX_W-1:0] smp_idx,
   output logic             bit0_pulse,
   output logic             bad_gap
);
   timeunit 1ns; timeprecision 1ps;

   logic             pend, ph, locked, fresh;
   logic [IDX_W-1:0] nxt, base, flen_m1;
   logic             fp_ev, dt_ev, fp_hit, start, ph_cur;

   always_comb begin
      fp_ev   = cfg.fp_edge ? fall : rise;
      dt_ev   = cfg.data_edge ? fall : rise;
      fp_hit  = fp_ev & (fp_raw ^ cfg.fp_low);
      start   = dt_ev & (pend | fp_hit);
      ph_cur  = start ? 1'b0 : ~ph;
      base    = start ? '0 : nxt;
      flen_m1 = cfg.t1 ? IDX_W'(T1_BITS - 1) : IDX_W'(E1_BITS - 1);
      smp     = dt_ev & (locked | start) & (~cfg.dbl | (ph_cur == cfg.dbl_pick));
      smp_idx = base;
      bit0_pulse = smp & (start | fresh);
      bad_gap    = start & locked & (nxt != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         ph     <= 1'b0;
         locked <= 1'b0;
         fresh  <= 1'b0;
         nxt    <= '0;
      end else begin
         pend <= (pend | fp_hit) & ~dt_ev;
         if (dt_ev) ph <= ph_cur;
         if (start) locked <= 1'b1;
         fresh <= smp ? 1'b0 : (start | fresh);
         if (smp)        nxt <= (base == flen_m1) ? '0 : base + 1'b1;
         else if (start) nxt <= base;
      end
   end
endmodule

// File: rtl/sfr_deser.sv
module sfr_deser #(
   parameter int IDX_W     = 8,
   parameter int CH_BITS   = 8,
   parameter int CHAN_W    = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp,
   input  logic [IDX_W-1:0]   smp_idx,
   input  logic               bit0_pulse,
   input  logic               d_bit,
   input  logic               s_bit,
   input  logic               t1,
   input  logic               fp_multi,
   output logic               byte_valid,
   output logic [CH_BITS-1:0] byte_data,
   output logic [CH_BITS-1:0] sig_byte,
   output logic [CHAN_W-1:0]  byte_chan,
   output logic               frame_start,
   output logic               mf_start
);
   timeunit 1ns; timeprecision 1ps;

   localparam int CH_LOG = $clog2(CH_BITS);

   if (CH_LOG + CHAN_W > IDX_W) begin : g_bad_width
      $error("sfr_deser: channel field exceeds bit index width");
   end

   logic [CH_BITS-1:0] dsh, ssh, dsh_n, ssh_n;
   logic [IDX_W-1:0]   pos;
   logic               fbit, last;

   if (MSB_FIRST) begin : g_msb
      assign dsh_n = {dsh[CH_BITS-2:0], d_bit};
      assign ssh_n = {ssh[CH_BITS-2:0], s_bit};
   end else begin : g_lsb
      assign dsh_n = {d_bit, dsh[CH_BITS-1:1]};
      assign ssh_n = {s_bit, ssh[CH_BITS-1:1]};
   end

   always_comb begin
      pos  = t1 ? smp_idx - 1'b1 : smp_idx;
      fbit = t1 & (smp_idx == '0);
      last = (pos[CH_LOG-1:0] == {CH_LOG{1'b1}});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dsh         <= '0;
         ssh         <= '0;
         byte_valid  <= 1'b0;
         byte_data   <= '0;
         sig_byte    <= '0;
         byte_chan   <= '0;
         frame_start <= 1'b0;
         mf_start    <= 1'b0;
      end else begin
         byte_valid  <= 1'b0;
         frame_start <= smp & (smp_idx == '0);
         mf_start    <= bit0_pulse & fp_multi;
         if (smp && !fbit) begin
            dsh <= dsh_n;
            ssh <= ssh_n;
            if (last) begin
               byte_valid <= 1'b1;
               byte_data  <= dsh_n;
               sig_byte   <= ssh_n;
               byte_chan  <= pos[CH_LOG +: CHAN_W];
            end
         end
      end
   end
endmodule

// File: rtl/sfr_err.sv
module sfr_err (
   input  logic clk,
   input  logic rst_n,
   input  logic bad_gap,
   input  logic clr,
   input  logic en,
   output logic err,
   output logic irq
);
   timeunit 1ns; timeprecision 1ps;

   logic err_n;
   assign err_n = bad_gap | (err & ~clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= 1'b0;
         irq <= 1'b0;
      end else begin
         err <= err_n;
         irq <= err_n & en;
      end
   end
endmodule

// File: rtl/slave_frame_rx.sv
module slave_frame_rx import sfr_pkg::*; #(
   parameter int SYNC_STAGES = 2,
   parameter int T1_BITS     = 193,
   parameter int E1_BITS     = 256,
   parameter int CH_BITS     = 8,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bclk_in,
   input  logic                                fp_in,
   input  logic                                sd_in,
   input  logic                                sig_in,
   input  logic                                cfg_fp_edge,
   input  logic                                cfg_data_edge,
   input  logic                                cfg_dbl,
   input  logic                                cfg_dbl_pick,
   input  logic                                cfg_fp_multi,
   input  logic                                cfg_fp_low,
   input  logic                                cfg_t1,
   input  logic                                cfg_err_en,
   input  logic                                err_clr,
   output logic                                byte_valid,
   output logic [CH_BITS-1:0]                  byte_data,
   output logic [CH_BITS-1:0]                  sig_byte,
   output logic [$clog2(E1_BITS/CH_BITS)-1:0]  byte_chan,
   output logic                                frame_start,
   output logic                                mf_start,
   output logic                                err_sticky,
   output logic                                irq
);
   timeunit 1ns; timeprecision 1ps;

   localparam int IDX_W  = $clog2(E1_BITS);
   localparam int CHAN_W = $clog2(E1_BITS / CH_BITS);

   if ((CH_BITS & (CH_BITS - 1)) != 0 || CH_BITS < 2) begin : g_bad_ch
      $error("slave_frame_rx: CH_BITS must be a power of two");
   end
   if (T1_BITS >= E1_BITS || (E1_BITS % CH_BITS) != 0) begin : g_bad_len
      $error("slave_frame_rx: frame lengths inconsistent");
   end

   rx_cfg_t          cfg;
   logic             rise, fall;
   logic [2:0]       sdat;
   logic             smp, bit0_pulse, bad_gap;
   logic [IDX_W-1:0] smp_idx;

   assign cfg = '{fp_edge: cfg_fp_edge, data_edge: cfg_data_edge, dbl: cfg_dbl,
                  dbl_pick: cfg_dbl_pick, fp_multi: cfg_fp_multi,
                  fp_low: cfg_fp_low, t1: cfg_t1};

   sfr_sync_edge #(.STAGES(SYNC_STAGES), .DW(3)) u_sync (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in),
      .din({fp_in, sd_in, sig_in}),
      .rise(rise), .fall(fall), .dout(sdat)
   );

   sfr_bit_timer #(.IDX_W(IDX_W), .T1_BITS(T1_BITS), .E1_BITS(E1_BITS)) u_timer (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .fp_raw(sdat[2]),
      .cfg(cfg), .smp(smp), .smp_idx(smp_idx), .bit0_pulse(bit0_pulse),
      .bad_gap(bad_gap)
   );

   sfr_deser #(.IDX_W(IDX_W), .CH_BITS(CH_BITS), .CHAN_W(CHAN_W),
               .MSB_FIRST(MSB_FIRST)) u_deser (
      .clk(clk), .rst_n(rst_n), .smp(smp), .smp_idx(smp_idx),
      .bit0_pulse(bit0_pulse), .d_bit(sdat[1]), .s_bit(sdat[0]),
      .t1(cfg_t1), .fp_multi(cfg_fp_multi),
      .byte_valid(byte_valid), .byte_data(byte_data), .sig_byte(sig_byte),
      .byte_chan(byte_chan), .frame_start(frame_start), .mf_start(mf_start)
   );

   sfr_err u_err (
      .clk(clk), .rst_n(rst_n), .bad_gap(bad_gap), .clr(err_clr),
      .en(cfg_err_en), .err(err_sticky), .irq(irq)
   );
endmodule

// File: rtl/sfr_rx_chk.sv
module sfr_rx_chk #(
   parameter int CHAN_W = 5,
   parameter int T1_CH  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_t1,
   input logic              byte_valid,
   input logic [CHAN_W-1:0] byte_chan,
   input logic              frame_start,
   input logic              mf_start,
   input logic              err_sticky,
   input logic              err_clr,
   input logic              irq
);
   timeunit 1ns; timeprecision 1ps;

   // R6
   t1_chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && cfg_t1) |-> (byte_chan < CHAN_W'(T1_CH)));

   // R7
   start_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> !byte_valid);

   // R8
   mf_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mf_start |-> frame_start);

   // R11
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !err_clr) |=> err_sticky);

   // R12
   irq_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> err_sticky);
endmodule

bind slave_frame_rx sfr_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_t1(cfg_t1), .byte_valid(byte_valid),
   .byte_chan(byte_chan), .frame_start(frame_start), .mf_start(mf_start),
   .err_sticky(err_sticky), .err_clr(err_clr), .irq(irq)
);

// File: tb/slave_frame_rx_test.sv
module slave_frame_rx_test;
   timeunit 1ns; timeprecision 1ps;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, bclk = 1'b0, fp = 1'b0, sd = 1'b0, sg = 1'b0, err_clr = 1'b0;
   logic c_t1 = 0, c_dbl = 0, c_pick = 0, c_fpe = 0, c_dte = 0, c_fpl = 0;
   logic c_multi = 0, c_en = 0;
   logic       byte_valid, frame_start, mf_start, err_sticky, irq;
   logic [7:0] byte_data, sig_byte;
   logic [4:0] byte_chan;

   int checks = 0, errors = 0;
   int nb = 0, nfs = 0, nmf = 0;
   logic [7:0] md [512];
   logic [7:0] ms [512];
   int         mc [512];

   slave_frame_rx uut (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fp_in(fp), .sd_in(sd), .sig_in(sg),
      .cfg_fp_edge(c_fpe), .cfg_data_edge(c_dte), .cfg_dbl(c_dbl),
      .cfg_dbl_pick(c_pick), .cfg_fp_multi(c_multi), .cfg_fp_low(c_fpl),
      .cfg_t1(c_t1), .cfg_err_en(c_en), .err_clr(err_clr),
      .byte_valid(byte_valid), .byte_data(byte_data), .sig_byte(sig_byte),
      .byte_chan(byte_chan), .frame_start(frame_start), .mf_start(mf_start),
      .err_sticky(err_sticky), .irq(irq)
   );

   // {t1, dbl, pick, fp_edge, data_edge, fp_low}
   localparam int NV = 10;
   localparam logic [5:0] VEC [NV] = '{
      6'b000000, 6'b000100, 6'b000011, 6'b100000, 6'b100111,
      6'b010000, 6'b011000, 6'b011100, 6'b010011, 6'b111110
   };

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid) begin
            if (nb < 512) begin
               md[nb] = byte_data; ms[nb] = sig_byte; mc[nb] = int'(byte_chan);
            end
            nb++;
         end
         if (frame_start) nfs++;
         if (mf_start) nmf++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat_d(int j, int c);
      return 8'((c * 29 + j * 71 + 90) & 255);
   endfunction
   function automatic logic [7:0] pat_s(int j, int c);
      return 8'((c * 13 + j * 5 + 3) & 255);
   endfunction

   function automatic logic frame_bit(int j, int b, bit s);
      int pos;
      logic [7:0] v;
      if (c_t1 && b == 0) return s ? 1'b0 : j[0];
      pos = c_t1 ? b - 1 : b;
      v = s ? pat_s(j, pos / 8) : pat_d(j, pos / 8);
      return v[7 - (pos % 8)];
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; bclk = 1'b0; fp = c_fpl; sd = 1'b0; sg = 1'b0; err_clr = 1'b0;
      repeat (5) @(negedge clk);
      nb = 0; nfs = 0; nmf = 0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // skip: frame index with no pulse, -2 = no pulse at all; late: frame index
   // preceded by one filler bit (-1 = none)
   task automatic run(input int nfr, input int skip, input int late);
      int flen = c_t1 ? 193 : 256;
      int epb  = c_dbl ? 4 : 2;
      int fe   = flen * epb;
      int p0   = 8 + int'(c_fpe);
      int doff = (c_fpe == c_dte) ? 0 : 1;
      int total = p0 + doff + nfr * fe + ((late >= 0) ? epb : 0);
      for (int e = 0; e < total; e++) begin
         logic act = 1'b0, dv = 1'b1, sv = 1'b1;
         int fj = -1, kk = 0;
         for (int j = 0; j < nfr; j++) begin
            int sj = p0 + j * fe + ((late >= 0 && j >= late) ? epb : 0);
            if (e == sj && j != skip && skip != -2) act = 1'b1;
            if (e >= sj + doff) begin fj = j; kk = e - sj - doff; end
         end
         if (fj >= 0) begin
            int b = kk / epb;
            logic inv = c_dbl && (((kk / 2) % 2) != int'(c_pick));
            if (b < flen) begin
               dv = frame_bit(fj, b, 1'b0) ^ inv;
               sv = frame_bit(fj, b, 1'b1) ^ inv;
            end else begin
               dv = 1'b0; sv = 1'b0;
            end
         end
         sd = dv; sg = sv; fp = act ^ c_fpl;
         repeat (2) @(negedge clk);
         bclk = ~bclk;
         repeat (2) @(negedge clk);
      end
      fp = c_fpl;
      repeat (10) @(negedge clk);
   endtask

   task automatic check_bytes(input int nfr, input string req);
      int nch = c_t1 ? 24 : 32;
      int bad = 0;
      check(nb == nfr * nch, req, nb, nfr * nch);
      for (int i = 0; i < nfr * nch && i < nb && i < 512; i++) begin
         int j = i / nch, c = i % nch;
         if (md[i] !== pat_d(j, c) || ms[i] !== pat_s(j, c) || mc[i] != c) begin
            if (bad == 0)
               $display("FAIL %s byte %0d actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                        req, i, md[i], ms[i], mc[i], pat_d(j, c), pat_s(j, c), c);
            bad++;
         end
      end
      checks++;
      if (bad != 0) errors++;
   endtask

   initial begin
      #950000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check({byte_valid, frame_start, mf_start, err_sticky, irq} == 5'b0, "R1 flags",
            int'({byte_valid, frame_start, mf_start, err_sticky, irq}), 0);
      check({byte_data, sig_byte, byte_chan} == 21'b0, "R1 data", int'(byte_data), 0);

      // table of edge / rate / polarity / format combinations
      for (int v = 0; v < NV; v++) begin
         {c_t1, c_dbl, c_pick, c_fpe, c_dte, c_fpl} = VEC[v];
         c_multi = 1'b0; c_en = 1'b1;
         do_reset();
         run(2, -1, -1);
         check_bytes(2, "R2/R3/R4/R5/R6");
         check(nfs == 2, "R7", nfs, 2);
         check(err_sticky == 1'b0, "R10 no false error", int'(err_sticky), 0);
      end

      // R9: no pulse at all
      {c_t1, c_dbl, c_pick, c_fpe, c_dte, c_fpl} = 6'b000000;
      do_reset();
      run(1, -2, -1);
      check(nb == 0, "R9 bytes", nb, 0);
      check(nfs == 0, "R9 frame_start", nfs, 0);

      // R7 / R8: multiframe pulses, middle pulse missing
      c_multi = 1'b1;
      do_reset();
      run(3, 1, -1);
      check_bytes(3, "R7 wrap");
      check(nfs == 3, "R7", nfs, 3);
      check(nmf == 2, "R8 multi", nmf, 2);
      check(err_sticky == 1'b0, "R10 skip ok", int'(err_sticky), 0);

      c_multi = 1'b0;
      do_reset();
      run(2, -1, -1);
      check(nmf == 0, "R8 off", nmf, 0);

      // R10 / R12 / R11: late pulse with interrupt enabled
      c_en = 1'b1;
      do_reset();
      run(2, -1, 1);
      check(err_sticky == 1'b1, "R10 late pulse", int'(err_sticky), 1);
      check(irq == 1'b1, "R12 enabled", int'(irq), 1);
      repeat (3) @(negedge clk);
      check(err_sticky == 1'b1, "R11 hold", int'(err_sticky), 1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      @(negedge clk);
      check(err_sticky == 1'b0, "R11 clear", int'(err_sticky), 0);
      check(irq == 1'b0, "R12 after clear", int'(irq), 0);

      // R12 masked, 193-bit frame
      {c_t1, c_dbl, c_pick, c_fpe, c_dte, c_fpl} = 6'b100000;
      c_en = 1'b0;
      do_reset();
      run(2, -1, 1);
      check(err_sticky == 1'b1, "R10 late pulse t1", int'(err_sticky), 1);
      check(irq == 1'b0, "R12 masked", int'(irq), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule